// File: doc/BRIEF.md
# Split Serial Access Register

This block is the serial side of a dual-ported video memory. It keeps a register of 256 words, each 16 bits wide. The register is filled from one row of the main array, which arrives as a wide row-data bus. It is then read out one word for each serial clock enable. A pointer selects the next word to send. As the pointer moves, it marks which half of the register is being read: the lower half holds words 0 to 127 and the upper half holds words 128 to 255.

There are two kinds of load. A full transfer replaces every word and moves the pointer to a chosen start tap; it suits idle periods such as retrace. A split transfer rewrites only the half that is not being read and leaves the pointer alone, so the host can keep a stream running without a gap. A split transfer aimed at the half in use is refused and reported. Outside transfers, shifting does not depend on what the array side is doing.

Top module: `split_sam`

## Requirements
- R1: After reset, `sdata`, `half_act`, `boundary` and `xfer_err` are 0 and the pointer is at word 0.
- R2: A cycle with `shift_en` high (and no full transfer) places the word at the pointer on `sdata` after that edge and advances the pointer by one. The pointer wraps from word 255 to word 0.
- R3: A full transfer (`xfer_req`=1, `xfer_split`=0) loads word i of the register from `row_data[16*i +: 16]` for all 256 words and sets the pointer to `xfer_tap`.
- R4: If `shift_en` is high in the same cycle as a full transfer, the shift is ignored: `sdata` holds and the pointer takes the tap.
- R5: `half_act` is 0 while the pointer is in words 0..127 and 1 while it is in words 128..255. It changes only on a shift or a full transfer.
- R6: `boundary` is high for exactly one cycle, right after the shift that sends word 127 or word 255.
- R7: A split transfer (`xfer_split`=1) with `xfer_half` not equal to `half_act` loads only the half that `xfer_half` names (0 = lower, 1 = upper). The other half and the pointer are unchanged.
- R8: A split transfer with `xfer_half` equal to `half_act` changes no word and raises `xfer_err` for one cycle after the request.
- R9: A split transfer and a shift in the same cycle both take effect. The shifted word comes from the active half and is not disturbed by the load.
- R10: With `shift_en` low and no transfer, `sdata` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_req | input | 1 | Transfer request, acted on at this edge |
| xfer_split | input | 1 | 1 = split transfer, 0 = full transfer |
| xfer_half | input | 1 | Target half for a split transfer (0 lower, 1 upper) |
| xfer_tap | input | 8 | Start word for a full transfer |
| shift_en | input | 1 | Serial clock enable: send one word |
| row_data | input | 4096 | Row from the main array, word i at bits 16*i+15..16*i |
| sdata | output | 16 | Serial output word |
| half_act | output | 1 | Half that the pointer is in |
| boundary | output | 1 | One-cycle pulse after a half crossing |
| xfer_err | output | 1 | One-cycle pulse for a refused split transfer |

## Verification
The hardest cases to reach from the ports are a split load that lands on the same edge as a shift. The worst of these is the shift that sends word 127 or 255 while the other half is being reloaded, because the very next word must already come from the new data. The stimulus streams several full passes through the register with shifting on every cycle. On each pass it issues split loads of the idle half at chosen distances from the crossing, including on the crossing edge itself. A reference copy kept by the bench, and filled by the requirements alone, predicts every output word. Refused split loads are checked by streaming through the half they aimed at and comparing each word.

// File: rtl/split_sam.sv
module split_sam #(
  parameter int WORDS = 256,
  parameter int WIDTH = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     xfer_req,
  input  logic                     xfer_split,
  input  logic                     xfer_half,
  input  logic [$clog2(WORDS)-1:0] xfer_tap,
  input  logic                     shift_en,
  input  logic [WORDS*WIDTH-1:0]   row_data,
  output logic [WIDTH-1:0]         sdata,
  output logic                     half_act,
  output logic                     boundary,
  output logic                     xfer_err
);
  localparam int AW   = $clog2(WORDS);
  localparam int HALF = WORDS / 2;

  logic [WIDTH-1:0] mem [WORDS];
  logic [AW-1:0]    ptr;

  wire full_go   = xfer_req & ~xfer_split;
  wire split_go  = xfer_req & xfer_split & (xfer_half != ptr[AW-1]);
  wire split_bad = xfer_req & xfer_split & (xfer_half == ptr[AW-1]);
  wire step      = shift_en & ~full_go;

  assign half_act = ptr[AW-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr      <= '0;
      sdata    <= '0;
      boundary <= 1'b0;
      xfer_err <= 1'b0;
    end else begin
      boundary <= step & (&ptr[AW-2:0]);
      xfer_err <= split_bad;
      if (full_go)   ptr <= xfer_tap;
      else if (step) ptr <= ptr + 1'b1;
      if (step)      sdata <= mem[ptr];
    end
  end

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    localparam bit UPPER = (g >= HALF);
    always_ff @(posedge clk) begin
      if (full_go || (split_go && (xfer_half == UPPER)))
        mem[g] <= row_data[g*WIDTH +: WIDTH];
    end
  end
endmodule

// File: rtl/split_sam_chk.sv
module split_sam_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             xfer_req,
  input logic             xfer_split,
  input logic             shift_en,
  input logic [WIDTH-1:0] sdata,
  input logic             half_act,
  input logic             boundary,
  input logic             xfer_err
);
  p_err_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_err |-> $past(xfer_req && xfer_split));

  p_boundary_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |=> !boundary);

  p_boundary_toggle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |-> (half_act != $past(half_act)));

  p_half_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(half_act) |-> $past(shift_en || (xfer_req && !xfer_split)));

  p_sdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(sdata));

  p_full_blocks_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req && !xfer_split) |=> $stable(sdata));
endmodule

bind split_sam split_sam_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/sim_split_sam.sv
module sim_split_sam;
  localparam int WORDS = 256;
  localparam int WIDTH = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic xfer_req = 0, xfer_split = 0, xfer_half = 0, shift_en = 0;
  logic [7:0] xfer_tap = '0;
  logic [WORDS*WIDTH-1:0] row_data = '0;
  logic [WIDTH-1:0] sdata;
  logic half_act, boundary, xfer_err;

  int n_chk = 0, n_bad = 0;
  logic [WIDTH-1:0] ref_mem [WORDS];
  logic [7:0] e_ptr;
  logic [WIDTH-1:0] e_sd;
  logic e_bnd, e_err;

  always #2.5 clk = ~clk;

  split_sam #(.WORDS(WORDS), .WIDTH(WIDTH)) u0 (.*);

  task automatic cmp(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic fill(input int seed);
    for (int i = 0; i < WORDS; i++)
      row_data[i*WIDTH +: WIDTH] = 16'((seed * 4099 + i * 37 + seed * i) & 16'hffff);
  endtask

  task automatic cyc(input bit sh, input bit req, input bit sp, input bit hf,
                     input int tap, input string tag);
    bit full, okspl, bad;
    full  = req && !sp;
    okspl = req && sp && (hf != e_ptr[7]);
    bad   = req && sp && (hf == e_ptr[7]);
    shift_en = sh; xfer_req = req; xfer_split = sp; xfer_half = hf; xfer_tap = 8'(tap);
    e_bnd = sh && !full && (e_ptr[6:0] == 7'h7f);
    e_err = bad;
    if (sh && !full) e_sd = ref_mem[e_ptr];
    for (int i = 0; i < WORDS; i++)
      if (full || (okspl && ((i >= 128) == hf))) ref_mem[i] = row_data[i*WIDTH +: WIDTH];
    if (full) e_ptr = 8'(tap);
    else if (sh) e_ptr = e_ptr + 8'd1;
    @(negedge clk);
    shift_en = 0; xfer_req = 0; xfer_split = 0;
    cmp(tag, "sdata", sdata, e_sd);
    cmp(tag, "half_act", half_act, e_ptr[7]);
    cmp(tag, "boundary", boundary, e_bnd);
    cmp(tag, "xfer_err", xfer_err, e_err);
  endtask

  initial begin
    #(5 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < WORDS; i++) ref_mem[i] = '0;
    e_ptr = 0; e_sd = 0; e_bnd = 0; e_err = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    cmp("R1", "sdata", sdata, 0);
    cmp("R1", "half_act", half_act, 0);
    cmp("R1", "boundary", boundary, 0);
    cmp("R1", "xfer_err", xfer_err, 0);

    // R3: full load from tap 0, then R2/R5/R6 full sweep with wrap
    fill(1);
    cyc(0, 1, 0, 0, 0, "R3");
    for (int k = 0; k < WORDS + 4; k++) cyc(1, 0, 0, 0, 0, "R2_R5_R6");

    // R10: idle holds
    for (int k = 0; k < 3; k++) cyc(0, 0, 0, 0, 0, "R10");

    // R4: full transfer with a shift in the same cycle, tap in upper half
    fill(2);
    cyc(1, 1, 0, 0, 200, "R4");
    for (int k = 0; k < 70; k++) cyc(1, 0, 0, 0, 0, "R3_R2");

    // R8: split aimed at the active half is refused; stream through it
    fill(3);
    cyc(0, 1, 1, e_ptr[7], 0, "R8");
    cyc(1, 1, 1, e_ptr[7], 0, "R8");
    for (int k = 0; k < WORDS; k++) cyc(1, 0, 0, 0, 0, "R8");

    // R7/R9: continuous streaming, split load of idle half at varied offsets
    for (int pass = 0; pass < 8; pass++) begin
      int off;
      off = (pass * 29) % 128;
      for (int k = 0; k < WORDS; k++) begin
        if ((e_ptr[6:0] == 7'(off)) || (pass == 3 && e_ptr[6:0] == 7'h7f)) begin
          fill(10 + pass * 2 + int'(e_ptr[7]));
          cyc(1, 1, 1, !e_ptr[7], 0, "R7_R9");
        end else begin
          cyc(1, 0, 0, 0, 0, "R9");
        end
      end
    end

    // R7: split with no shift, then idle, then stream through both halves
    fill(40);
    cyc(0, 1, 1, !e_ptr[7], 0, "R7");
    cyc(0, 0, 0, 0, 0, "R10");
    for (int k = 0; k < WORDS; k++) cyc(1, 0, 0, 0, 0, "R7");

    // R3: full transfer to tap 127 right before a crossing
    fill(50);
    cyc(0, 1, 0, 0, 127, "R3");
    for (int k = 0; k < 4; k++) cyc(1, 0, 0, 0, 0, "R6");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule